// File: doc/BRIEF.md
# Bus Handshake Fetch-Execute Sequencer

This block is the control core of a very small processor. It drives a system bus with a 16-bit address, an 8-bit data path and three control lines: a read strobe, a write strobe and an acknowledge that memory returns. Each transfer lasts as long as the memory takes. The block raises a strobe and holds it until the acknowledge arrives, so one design works with fast and slow memories alike. The data path is split into a write half that the block drives and a read half that memory drives.

After reset the block fetches an opcode from the start address and moves it from the data register into the instruction register. It then decodes it. Only one opcode does anything: it adds an immediate byte to a byte in memory. The instruction is four bytes long: the opcode, the low byte of the target address, the high byte of the target address, and the immediate byte. To execute it, the block reads the target byte and parks it in a temporary register. It adds the immediate to it and writes the sum back to the same address. Any other opcode is skipped, and fetching goes on at the next byte.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is held, both strobes are low. The first transfer after reset is a read at address 0100h.
- R2: The read strobe and the write strobe are never high in the same cycle.
- R3: A strobe stays high until the cycle in which acknowledge is sampled high. It is low in the following cycle.
- R4: While a strobe is high and not yet acknowledged, the address is held steady. During a write, the write data is held steady as well.
- R5: The read data lines are captured only in a cycle where a read is acknowledged. Values on them at any other time have no effect.
- R6: Opcode 3Ch is followed by the address low byte, then the address high byte, then the immediate byte, each read from the next address. The program counter moves past every byte fetched, so the next opcode is read 4 bytes after 3Ch.
- R7: For opcode 3Ch, after the instruction bytes are fetched, the block reads the target address once. It then writes the sum to that same address, and that write is its next transfer.
- R8: Any opcode other than 3Ch causes no operand read and no write. The next opcode is fetched from the following address.
- R9: The written sum is the operand plus the immediate, modulo 256. Any carry out is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | output | 16 | Address bus, driven from the address register |
| bus_wdata | output | 8 | Write half of the data bus, driven from the data register |
| bus_rdata | input | 8 | Read half of the data bus, driven by memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_ack | input | 1 | Transfer acknowledge from memory |

## Verification
The checker runs every cycle and covers the handshake rules. It checks that the two strobes never overlap, that a strobe is held until acknowledge and falls one cycle after it, and that the address and write data do not move while a transfer is waiting. The bench's scenarios cover everything that depends on program content. They check the order of addresses across a whole instruction and the skipping of unknown opcodes. They check the modulo-256 sum, and they show that data placed on the read lines without an acknowledge is ignored. To do this, the bench compares every acknowledged transfer and the final memory image against a reference model, using random memory latencies.

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] START_ADDR = 16'h0100,
  parameter logic [DW-1:0] ADD_OPCODE = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_ack
);

  typedef enum logic [3:0] {
    ST_OPC, ST_IR, ST_DEC, ST_ALO, ST_AHI, ST_IMM,
    ST_OPND, ST_HOLD, ST_ADD, ST_WR
  } state_t;

  localparam logic [AW-1:0] PC_STEP = {{(AW-1){1'b0}}, 1'b1};

  state_t        state;
  logic [AW-1:0] pc, ar, ea;
  logic [DW-1:0] dr, ir, imm, tmp;
  logic          rd_q, wr_q;

  logic fetch_state;
  logic rd_done;
  assign fetch_state = (state == ST_OPC) || (state == ST_ALO) ||
                       (state == ST_AHI) || (state == ST_IMM);
  assign rd_done     = rd_q && mem_ack;

  assign bus_addr  = ar;
  assign bus_wdata = dr;
  assign mem_rd    = rd_q;
  assign mem_wr    = wr_q;

  function automatic state_t after_fetch(input state_t s);
    case (s)
      ST_OPC:  after_fetch = ST_IR;
      ST_ALO:  after_fetch = ST_AHI;
      ST_AHI:  after_fetch = ST_IMM;
      default: after_fetch = ST_OPND;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_OPC;
      pc    <= START_ADDR;
      ar    <= '0;
      ea    <= '0;
      dr    <= '0;
      ir    <= '0;
      imm   <= '0;
      tmp   <= '0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else if (fetch_state) begin
      if (!rd_q) begin
        ar   <= pc;
        rd_q <= 1'b1;
        if (state == ST_AHI) ea[DW-1:0]  <= dr;
        if (state == ST_IMM) ea[AW-1:DW] <= dr;
      end else if (rd_done) begin
        dr    <= bus_rdata;
        rd_q  <= 1'b0;
        pc    <= pc + PC_STEP;
        state <= after_fetch(state);
      end
    end else begin
      case (state)
        ST_IR: begin
          ir    <= dr;
          state <= ST_DEC;
        end
        ST_DEC: state <= (ir == ADD_OPCODE) ? ST_ALO : ST_OPC;
        ST_OPND: begin
          if (!rd_q) begin
            imm  <= dr;
            ar   <= ea;
            rd_q <= 1'b1;
          end else if (rd_done) begin
            dr    <= bus_rdata;
            rd_q  <= 1'b0;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          tmp   <= dr;
          state <= ST_ADD;
        end
        ST_ADD: begin
          tmp   <= tmp + imm;
          state <= ST_WR;
        end
        ST_WR: begin
          if (!wr_q) begin
            dr   <= tmp;
            ar   <= ea;
            wr_q <= 1'b1;
          end else if (mem_ack) begin
            wr_q  <= 1'b0;
            state <= ST_OPC;
          end
        end
        default: state <= ST_OPC;
      endcase
    end
  end

endmodule

// File: rtl/fetch_exec_seq_chk.sv
module fetch_exec_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_ack
);

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r3_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> mem_rd);

  a_r3_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> mem_wr);

  a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && mem_ack) |=> (!mem_rd && !mem_wr));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ack) |=> $stable(bus_addr));

  a_r4_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> $stable(bus_wdata));

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!mem_rd && !mem_wr));

endmodule

bind fetch_exec_seq fetch_exec_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ack(mem_ack)
);

// File: tb/fetch_exec_seq_tb.sv
module fetch_exec_seq_tb;
  localparam logic [7:0] ADD_OP = 8'h3C;
  localparam int MAXX = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = 8'h00;
  logic        mem_rd, mem_wr;
  logic        mem_ack = 1'b0;

  fetch_exec_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ack(mem_ack)
  );

  always #5 clk = ~clk;

  logic [7:0]  mem  [0:65535];
  logic [7:0]  emem [0:65535];
  logic [15:0] x_addr [MAXX];
  logic        x_wr   [MAXX];
  logic [7:0]  x_data [MAXX];
  string       x_req  [MAXX];
  int n_exp = 0, x_idx = 0, wait_cnt = 0;
  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic w, input logic [7:0] d,
                      input string req);
    if (n_exp < MAXX) begin
      x_addr[n_exp] = a; x_wr[n_exp] = w; x_data[n_exp] = d; x_req[n_exp] = req;
      n_exp++;
    end
  endtask

  function automatic logic [7:0] add8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0];
  endfunction

  task automatic build_exp(input int n_instr);
    logic [15:0] pc, ea;
    logic [7:0]  op, imm, v;
    bit prev_nop;
    for (int i = 0; i < 65536; i++) emem[i] = mem[i];
    n_exp = 0; x_idx = 0; pc = 16'h0100; prev_nop = 0;
    for (int i = 0; i < n_instr; i++) begin
      op = emem[pc];
      push(pc, 1'b0, 8'h00, (i == 0) ? "R1" : (prev_nop ? "R8" : "R6"));
      pc++;
      if (op == ADD_OP) begin
        push(pc, 1'b0, 8'h00, "R6"); ea[7:0]  = emem[pc]; pc++;
        push(pc, 1'b0, 8'h00, "R6"); ea[15:8] = emem[pc]; pc++;
        push(pc, 1'b0, 8'h00, "R6"); imm      = emem[pc]; pc++;
        push(ea, 1'b0, 8'h00, "R7");
        v = add8(emem[ea], imm);
        push(ea, 1'b1, v, "R9");
        emem[ea] = v;
        prev_nop = 0;
      end else prev_nop = 1;
    end
  endtask

  // memory responder with random latency; junk on read lines when idle (R5)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 1'b0;
        check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
      end else if (mem_ack) begin
        mem_ack = 1'b0;
        check(!mem_rd && !mem_wr, "R3", "strobe after ack", {mem_rd, mem_wr}, 0);
        wait_cnt = int'($urandom % 4);
      end else if (mem_rd || mem_wr) begin
        if (wait_cnt != 0) wait_cnt--;
        else begin
          mem_ack = 1'b1;
          if (x_idx < n_exp) begin
            check(bus_addr == x_addr[x_idx], x_req[x_idx], "address", bus_addr, x_addr[x_idx]);
            check(mem_wr == x_wr[x_idx], x_req[x_idx], "direction", mem_wr, x_wr[x_idx]);
            if (x_wr[x_idx])
              check(bus_wdata == x_data[x_idx], x_req[x_idx], "write data", bus_wdata, x_data[x_idx]);
            x_idx++;
          end
          if (mem_wr) mem[bus_addr] = bus_wdata;
        end
      end
      bus_rdata = mem_ack ? mem[bus_addr] : 8'($urandom);
    end
  end

  task automatic run_prog(input int n_instr);
    int cyc;
    build_exp(n_instr);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (x_idx < n_exp && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    check(x_idx == n_exp, "R3", "watchdog transfers", x_idx, n_exp);
    repeat (2) @(posedge clk);
    for (int a = 16'h2000; a < 16'h2100; a++)
      if (mem[a] != emem[a]) check(0, "R7", "final memory", mem[a], emem[a]);
    n_checks++;
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    void'($urandom(32'd1234));

    // directed: example sum, two no-ops, wrap, accumulate
    mem[16'h2000] = 8'h85; mem[16'h2001] = 8'hFF;
    mem[16'h0100] = ADD_OP; mem[16'h0101] = 8'h00; mem[16'h0102] = 8'h20; mem[16'h0103] = 8'h50;
    mem[16'h0104] = 8'h00; mem[16'h0105] = 8'h7F;
    mem[16'h0106] = ADD_OP; mem[16'h0107] = 8'h01; mem[16'h0108] = 8'h20; mem[16'h0109] = 8'h02;
    mem[16'h010A] = ADD_OP; mem[16'h010B] = 8'h00; mem[16'h010C] = 8'h20; mem[16'h010D] = 8'hFF;
    run_prog(5);
    check(mem[16'h2000] == 8'hD4, "R7", "85+50+FF", mem[16'h2000], 8'hD4);
    check(mem[16'h2001] == 8'h01, "R9", "FF+02 wrap", mem[16'h2001], 8'h01);

    // random programs
    for (int r = 0; r < 3; r++) begin
      int p;
      for (int a = 16'h0100; a < 16'h0400; a++) mem[a] = 8'h00;
      for (int a = 16'h2000; a < 16'h2100; a++) mem[a] = 8'($urandom);
      p = 16'h0100;
      for (int i = 0; i < 40; i++) begin
        if ($urandom % 2 == 0) begin
          mem[p] = ADD_OP;
          mem[p+1] = 8'($urandom % 16);
          mem[p+2] = 8'h20;
          mem[p+3] = 8'($urandom);
          p += 4;
        end else begin
          logic [7:0] op;
          op = 8'($urandom);
          if (op == ADD_OP) op = 8'h3D;
          mem[p] = op;
          p += 1;
        end
      end
      run_prog(40);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule